// File: doc/BRIEF.md
# Endpoint Interrupt Status and Routing

This block keeps one pending interrupt bit per direction for every endpoint of a device controller. With the default of sixteen endpoints this is a 32-bit pending vector. Bits are raised by single-cycle event pulses from the endpoint hardware, or by software through a set write. Software can drop bits with a clear write. A write-only priority mask steers each pending bit to one of two aggregate lines. A pending bit whose mask bit is 1 drives the fast line. A pending bit whose mask bit is 0 drives the slow line. A device-level override input moves every pending bit onto the fast line.

Software acknowledges one endpoint through a select-and-clear command. The command drops both of that endpoint's pending bits. It hands the two bits as they stood back through a small data register and raises a data-full flag. While the flag is high, further commands are dropped. Hardware does not wait for the data to be read; event pulses and register writes keep acting on the pending vector while the flag is high. Software lowers the flag before the next command.

Top module: `ep_irq_router`

## Requirements
- R1: Pending bit 2n belongs to the receive direction of endpoint n and bit 2n+1 to its transmit direction. The command data output carries {transmit, receive} of the selected endpoint in bits [1:0].
- R2: A set write makes every pending bit whose data bit is 1 high on the next cycle. Data bits of 0 leave their pending bits unchanged.
- R3: A clear write drops every pending bit whose data bit is 1 on the next cycle, unless the same bit is raised in that cycle. Data bits of 0 leave their pending bits unchanged.
- R4: A hardware event pulse on a bit makes that pending bit high on the next cycle. An event, or a set write, on a bit wins over a clear write or a command clear on that bit in the same cycle.
- R5: After reset, the pending vector, the priority mask, the data-full flag, the command data and both aggregate lines are all zero.
- R6: With the override low, the fast line is the OR of the pending bits whose priority bit is 1. The slow line is the OR of the pending bits whose priority bit is 0. Any number of bits may share either line.
- R7: While the override input is high, the slow line is low and the fast line is the OR of all pending bits.
- R8: A command presented while the data-full flag is low drops both pending bits of the selected endpoint. On the next cycle it places their pre-command values on the command data output and raises the data-full flag.
- R9: A command presented while the data-full flag is high has no effect: the pending vector, the command data and the flag are left as other inputs make them.
- R10: A flag-clear input lowers the data-full flag on the next cycle. While the flag is high, pending bits keep following events and register writes.
- R11: A priority write replaces the whole priority mask on the next cycle. The mask is observable only through the aggregate lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_evt_i | input | 2*NUM_EP | Endpoint event pulses, one per pending bit |
| set_we_i | input | 1 | Set write strobe |
| set_data_i | input | 2*NUM_EP | Set write data, 1 raises a bit |
| clr_we_i | input | 1 | Clear write strobe |
| clr_data_i | input | 2*NUM_EP | Clear write data, 1 drops a bit |
| pri_we_i | input | 1 | Priority write strobe |
| pri_data_i | input | 2*NUM_EP | New priority mask, 1 selects the fast line |
| force_fast_i | input | 1 | Device-level override, routes all to fast |
| cmd_valid_i | input | 1 | Select-and-clear command strobe |
| cmd_ep_i | input | $clog2(NUM_EP) | Endpoint number of the command |
| full_clr_i | input | 1 | Lowers the data-full flag |
| status_o | output | 2*NUM_EP | Pending vector |
| irq_fast_o | output | 1 | Fast aggregate interrupt |
| irq_slow_o | output | 1 | Slow aggregate interrupt |
| cmd_data_o | output | 2 | {transmit, receive} captured by the last accepted command |
| cmd_full_o | output | 1 | Data-full flag |

## Verification
The bench builds the block with its default of sixteen endpoints, so the full 32-bit vector is exercised. This includes commands to endpoint 15, whose bits sit at the top of the vector, and to endpoint 0 at the bottom. With this width, sparse random event pulses land on the same bit as random clear writes and commands often enough to exercise the event-wins rule. Frequent commands also meet a still-high data-full flag, so the dropped-command path is covered alongside the directed cases.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
    localparam int DIRS = 2;

    typedef struct packed {
        logic            full;
        logic [DIRS-1:0] data;
    } cmd_state_t;
endpackage

// File: rtl/ep_status_reg.sv
module ep_status_reg #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] hw_evt,
    input  logic             set_we,
    input  logic [NBITS-1:0] set_data,
    input  logic             clr_we,
    input  logic [NBITS-1:0] clr_data,
    input  logic [NBITS-1:0] cmd_clr_mask,
    output logic [NBITS-1:0] status_q
);
    logic [NBITS-1:0] status_d;

    for (genvar i = 0; i < NBITS; i++) begin : g_bit
        logic raise_b;
        logic drop_b;
        logic nxt_b;
        always_comb begin
            raise_b = hw_evt[i] | (set_we & set_data[i]);
            drop_b  = (clr_we & clr_data[i]) | cmd_clr_mask[i];
            // a raise beats a drop so no event is lost
            nxt_b   = raise_b | (status_q[i] & ~drop_b);
        end
        assign status_d[i] = nxt_b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((status_q & $past(set_data)) == $past(set_data))); // R2

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((status_q & $past(clr_data & ~hw_evt & ~(set_we ? set_data : '0))) == '0)); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_evt != '0) |=> ((status_q & $past(hw_evt)) == $past(hw_evt))); // R4

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we && hw_evt == '0 && cmd_clr_mask == '0) |=> $stable(status_q)); // R9
endmodule

// File: rtl/ep_route.sv
module ep_route #(
    parameter int NBITS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pri_we,
    input  logic [NBITS-1:0] pri_data,
    input  logic             force_fast,
    input  logic [NBITS-1:0] status,
    output logic             irq_fast,
    output logic             irq_slow
);
    logic [NBITS-1:0] pri_d, pri_q;
    logic [NBITS-1:0] fast_sel;

    always_comb begin
        pri_d    = pri_we ? pri_data : pri_q;
        fast_sel = force_fast ? '1 : pri_q;
        irq_fast = |(status & fast_sel);
        irq_slow = |(status & ~fast_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pri_q <= '0;
        else        pri_q <= pri_d;
    end

    AST_OVERRIDE_NO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        force_fast |-> !irq_slow); // R7

    AST_PENDING_REACHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (status != '0) |-> (irq_fast || irq_slow)); // R6

    AST_QUIET_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> (!irq_fast && !irq_slow)); // R6
endmodule

// File: rtl/ep_cmd_ctrl.sv
module ep_cmd_ctrl
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int NBITS = DIRS * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [EP_W-1:0]  cmd_ep,
    input  logic             full_clr,
    input  logic [NBITS-1:0] status,
    output logic [NBITS-1:0] clr_mask,
    output logic [DIRS-1:0]  cmd_data,
    output logic             cmd_full
);
    cmd_state_t st_d, st_q;
    logic       accept;

    assign accept = cmd_valid & ~st_q.full;

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        assign clr_mask[DIRS*e +: DIRS] =
            (accept && cmd_ep == EP_W'(e)) ? '1 : '0;
    end

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.data = status[DIRS*cmd_ep +: DIRS];
            st_d.full = 1'b1;
        end else if (full_clr) begin
            st_d.full = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_data = st_q.data;
    assign cmd_full = st_q.full;

    AST_CMD_RAISES_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_full) |=> cmd_full); // R8

    AST_BUSY_CMD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |=> $stable(cmd_data)); // R9

    AST_BUSY_NO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_full |-> (clr_mask == '0)); // R9

    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_full && full_clr) |=> !cmd_full); // R10
endmodule

// File: rtl/ep_irq_router.sv
module ep_irq_router
    import ep_irq_pkg::*;
#(
    parameter int NUM_EP = 16,
    localparam int NBITS = DIRS * NUM_EP,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] hw_evt_i,
    input  logic             set_we_i,
    input  logic [NBITS-1:0] set_data_i,
    input  logic             clr_we_i,
    input  logic [NBITS-1:0] clr_data_i,
    input  logic             pri_we_i,
    input  logic [NBITS-1:0] pri_data_i,
    input  logic             force_fast_i,
    input  logic             cmd_valid_i,
    input  logic [EP_W-1:0]  cmd_ep_i,
    input  logic             full_clr_i,
    output logic [NBITS-1:0] status_o,
    output logic             irq_fast_o,
    output logic             irq_slow_o,
    output logic [DIRS-1:0]  cmd_data_o,
    output logic             cmd_full_o
);
    logic [NBITS-1:0] cmd_clr_mask;
    logic [NBITS-1:0] status_q;

    ep_status_reg #(.NBITS(NBITS)) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_evt       (hw_evt_i),
        .set_we       (set_we_i),
        .set_data     (set_data_i),
        .clr_we       (clr_we_i),
        .clr_data     (clr_data_i),
        .cmd_clr_mask (cmd_clr_mask),
        .status_q     (status_q)
    );

    ep_route #(.NBITS(NBITS)) u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .pri_we     (pri_we_i),
        .pri_data   (pri_data_i),
        .force_fast (force_fast_i),
        .status     (status_q),
        .irq_fast   (irq_fast_o),
        .irq_slow   (irq_slow_o)
    );

    ep_cmd_ctrl #(.NUM_EP(NUM_EP)) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid_i),
        .cmd_ep    (cmd_ep_i),
        .full_clr  (full_clr_i),
        .status    (status_q),
        .clr_mask  (cmd_clr_mask),
        .cmd_data  (cmd_data_o),
        .cmd_full  (cmd_full_o)
    );

    assign status_o = status_q;

    AST_CMD_BITS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && !cmd_full_o && !set_we_i && !clr_we_i && hw_evt_i == '0)
        |=> (status_o[DIRS*$past(cmd_ep_i) +: DIRS] == '0)); // R8
endmodule

// File: tb/ep_irq_router_tb.sv
`timescale 1ns/1ps
module ep_irq_router_tb_top;
    localparam int NUM_EP = 16;
    localparam int NBITS  = 2 * NUM_EP;
    localparam int EP_W   = $clog2(NUM_EP);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NBITS-1:0] hw_evt = '0;
    logic             set_we = 1'b0;
    logic [NBITS-1:0] set_data = '0;
    logic             clr_we = 1'b0;
    logic [NBITS-1:0] clr_data = '0;
    logic             pri_we = 1'b0;
    logic [NBITS-1:0] pri_data = '0;
    logic             force_fast = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [EP_W-1:0]  cmd_ep = '0;
    logic             full_clr = 1'b0;
    logic [NBITS-1:0] status;
    logic             irq_fast, irq_slow;
    logic [1:0]       cmd_data;
    logic             cmd_full;

    int n_chk = 0;
    int n_fail = 0;

    logic [NBITS-1:0] m_status = '0;
    logic [NBITS-1:0] m_pri = '0;
    logic [1:0]       m_cmd = '0;
    logic             m_full = 1'b0;

    always #2 clk = ~clk;

    ep_irq_router #(.NUM_EP(NUM_EP)) dut_i (
        .clk(clk), .rst_n(rst_n), .hw_evt_i(hw_evt), .set_we_i(set_we),
        .set_data_i(set_data), .clr_we_i(clr_we), .clr_data_i(clr_data),
        .pri_we_i(pri_we), .pri_data_i(pri_data), .force_fast_i(force_fast),
        .cmd_valid_i(cmd_valid), .cmd_ep_i(cmd_ep), .full_clr_i(full_clr),
        .status_o(status), .irq_fast_o(irq_fast), .irq_slow_o(irq_slow),
        .cmd_data_o(cmd_data), .cmd_full_o(cmd_full)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic exp_fast();
        return |(m_status & (force_fast ? {NBITS{1'b1}} : m_pri));
    endfunction

    function automatic logic exp_slow();
        return !force_fast && |(m_status & ~m_pri);
    endfunction

    task automatic check_all();
        chk("R2 R3 R4 R8 R9 R10 pending", 64'(status), 64'(m_status));
        chk("R6 R7 R11 fast line", 64'(irq_fast), 64'(exp_fast()));
        chk("R6 R7 R11 slow line", 64'(irq_slow), 64'(exp_slow()));
        chk("R1 R8 R9 cmd data", 64'(cmd_data), 64'(m_cmd));
        chk("R8 R9 R10 full flag", 64'(cmd_full), 64'(m_full));
    endtask

    task automatic tick();
        logic             acc;
        logic [NBITS-1:0] drop, raise, n_st;
        acc   = cmd_valid && !m_full;
        drop  = (clr_we ? clr_data : '0) | (acc ? (NBITS'(3) << (2 * cmd_ep)) : '0);
        raise = (set_we ? set_data : '0) | hw_evt;
        n_st  = (m_status & ~drop) | raise;
        @(posedge clk);
        if (acc) m_cmd = m_status[2*cmd_ep +: 2];
        m_full   = acc ? 1'b1 : (full_clr ? 1'b0 : m_full);
        if (pri_we) m_pri = pri_data;
        m_status = n_st;
        @(negedge clk);
        check_all();
    endtask

    task automatic idle();
        hw_evt = '0; set_we = 0; set_data = '0; clr_we = 0; clr_data = '0;
        pri_we = 0; pri_data = '0; cmd_valid = 0; full_clr = 0;
    endtask

    initial begin
        #800000;
        n_chk++; n_fail++;
        $display("FAIL watchdog R8 R10 act=%0d exp=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd20250601));
        repeat (3) @(negedge clk);
        // R5 reset state
        chk("R5 reset pending", 64'(status), 64'(0));
        chk("R5 reset lines", 64'({irq_fast, irq_slow}), 64'(0));
        chk("R5 reset cmd", 64'({cmd_full, cmd_data}), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2: zero set data changes nothing, then set a few bits
        set_we = 1; set_data = '0; tick();
        set_data = 32'h8000_0005; tick(); idle();
        // R6: priority 0 everywhere -> slow only; R11 all fast
        tick();
        pri_we = 1; pri_data = '1; tick(); idle(); tick();
        pri_we = 1; pri_data = 32'h0000_0004; tick(); idle(); tick();
        // R7 override
        force_fast = 1; tick(); force_fast = 0; tick();
        // R4 event beats clear on same bit
        hw_evt = 32'h0000_0100; clr_we = 1; clr_data = 32'h0000_0301; tick(); idle();
        // R1 R8 command on endpoint 15 (bits 31:30)
        cmd_valid = 1; cmd_ep = 4'd15; tick(); idle();
        // R9 second command dropped while full; R10 events continue
        cmd_valid = 1; cmd_ep = 4'd4; hw_evt = 32'h0000_0002; tick(); idle();
        full_clr = 1; tick(); idle();
        // R8 R4 command on endpoint 4 with event on same bit
        cmd_valid = 1; cmd_ep = 4'd4; hw_evt = 32'h0000_0200; tick(); idle();
        full_clr = 1; tick(); idle();
        // R1 endpoint 0
        cmd_valid = 1; cmd_ep = 4'd0; tick(); idle(); full_clr = 1; tick(); idle();

        for (int i = 0; i < 4000; i++) begin
            hw_evt     = $urandom & $urandom & $urandom & $urandom;
            set_we     = ($urandom % 8) == 0;
            set_data   = $urandom & $urandom;
            clr_we     = ($urandom % 6) == 0;
            clr_data   = $urandom;
            pri_we     = ($urandom % 16) == 0;
            pri_data   = $urandom;
            force_fast = ($urandom % 8) == 0;
            cmd_valid  = ($urandom % 3) == 0;
            cmd_ep     = EP_W'($urandom);
            full_clr   = ($urandom % 4) == 0;
            tick();
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule